// File: doc/BRIEF.md
# Two-Wire Bus Unstick Sequencer

This block frees a two-wire serial bus when a slave that lost track of a transfer keeps the data line pulled low. A controller raises a one-cycle trigger after it has aborted a transfer and released its own bus control. The sequencer samples the sensed data level. If the line is already high it reports success at once and drives nothing. If the line is held low it toggles the clock line through a clock-low override, one pulse at a time, so the slave can shift out the rest of its byte. It stops pulsing once the data line reads high, or when a fixed number of pulses has been made. It then builds a STOP condition on the bus with the two override enables.

The width of every override step is a cycle count taken from an input when the trigger is accepted. When the sequence ends, a one-cycle done pulse is produced. A success flag, held until the next accepted trigger, reports whether the data line was high at the final sample.

Top module: `busfree_seq`

## Requirements
- R1: A trigger accepted while idle with the data line sensed high (`sda_i`=1) asserts no override and never raises busy. On the next cycle it gives a one-cycle done pulse with ok=1.
- R2: A trigger accepted while idle with `sda_i`=0 raises busy from the next cycle. Each recovery pulse keeps `scl_force_o`=1 for N cycles and then `scl_force_o`=0 for N cycles. `sda_force_o` stays 0 throughout the pulses.
- R3: `sda_i` is sampled in the last cycle of each released-clock phase. A further pulse follows only if it reads 0 and fewer than MAX_PULSES (default 9) pulses have been made. Otherwise the STOP steps begin.
- R4: The STOP is built in this order, each step N cycles long: both overrides at 1, then only `sda_force_o`=1, then both overrides at 0.
- R5: `ok_o` takes the value of `sda_i` in the last cycle of the final released step. `done_o` is high for exactly one cycle, namely the first cycle in which busy is low again. `ok_o` holds its value until the next accepted trigger.
- R6: N is the value of `phase_len_i` when the trigger is accepted, and a value of 0 counts as 1. Changes to `phase_len_i` during a run have no effect on that run.
- R7: A trigger that arrives while busy is ignored, and the running sequence keeps its length and shape.
- R8: After reset the block is idle, with both overrides, done and ok at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery trigger, sampled at a rising edge |
| sda_i | input | 1 | Sensed data-line level, 1 = high |
| phase_len_i | input | LEN_W | Cycles per override step (0 treated as 1) |
| scl_force_o | output | 1 | Clock-line low override enable |
| sda_force_o | output | 1 | Data-line low override enable |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Data line was high at the final sample |
| busy_o | output | 1 | Sequence in progress |

## Verification
Two events can land on the same sampling edge. The first is the end of a released-clock phase, where the data line decides between another pulse and the STOP. The second is the slave letting go of the line, which happens right after the clock override drops. The bench uses a slave model that holds the data line low for a chosen number of clock releases. It sweeps that number from zero to two past the pulse limit, so the release falls on every pulse and also on the clock release inside the STOP. A trigger and a new step length are also injected into every run. Each run is judged cycle by cycle against an override pattern, a busy length and an ok value that the bench computes from the hold count and N.

// File: rtl/busfree_pkg.sv
package busfree_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_BOTH,
        ST_STOP_SDA,
        ST_STOP_REL
    } bf_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bf_force_t;

    function automatic bf_force_t force_of(bf_state_e s);
        bf_force_t f;
        f.scl = (s == ST_LOW) || (s == ST_STOP_BOTH);
        f.sda = (s == ST_STOP_BOTH) || (s == ST_STOP_SDA);
        return f;
    endfunction

endpackage

// File: rtl/busfree_timer.sv
module busfree_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= len_i - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire_o = (cnt == '0);

    a_r2_timer_counts: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/busfree_ctrl.sv
module busfree_ctrl
    import busfree_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int MAX_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             sda_i,
    input  logic [LEN_W-1:0] phase_len_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [LEN_W-1:0] load_val_o,
    output logic             scl_force_o,
    output logic             sda_force_o,
    output logic             done_o,
    output logic             ok_o,
    output logic             busy_o
);
    localparam int PC_W = $clog2(MAX_PULSES + 1);

    bf_state_e        state, nxt;
    logic [LEN_W-1:0] len_q, len_eff;
    logic [PC_W-1:0]  pulses;
    logic             fin, accept, skip;
    bf_force_t        frc;

    assign len_eff = (phase_len_i == '0) ? LEN_W'(1) : phase_len_i;
    assign accept  = (state == ST_IDLE) && start_i;
    assign skip    = accept && sda_i;

    always_comb begin
        nxt        = state;
        load_o     = 1'b0;
        load_val_o = len_q;
        fin        = 1'b0;
        unique case (state)
            ST_IDLE: if (accept && !sda_i) begin
                nxt        = ST_LOW;
                load_o     = 1'b1;
                load_val_o = len_eff;
            end
            ST_LOW: if (expire_i) begin
                nxt    = ST_HIGH;
                load_o = 1'b1;
            end
            ST_HIGH: if (expire_i) begin
                load_o = 1'b1;
                if (!sda_i && (pulses < PC_W'(MAX_PULSES))) nxt = ST_LOW;
                else                                         nxt = ST_STOP_BOTH;
            end
            ST_STOP_BOTH: if (expire_i) begin
                nxt    = ST_STOP_SDA;
                load_o = 1'b1;
            end
            ST_STOP_SDA: if (expire_i) begin
                nxt    = ST_STOP_REL;
                load_o = 1'b1;
            end
            ST_STOP_REL: if (expire_i) begin
                nxt = ST_IDLE;
                fin = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            len_q  <= LEN_W'(1);
            pulses <= '0;
            done_o <= 1'b0;
            ok_o   <= 1'b0;
        end else begin
            state  <= nxt;
            done_o <= fin || skip;
            if (accept) begin
                len_q  <= len_eff;
                pulses <= sda_i ? '0 : PC_W'(1);
                ok_o   <= sda_i;
            end else if (state == ST_HIGH && nxt == ST_LOW) begin
                pulses <= pulses + 1'b1;
            end
            if (fin) ok_o <= sda_i;
        end
    end

    assign frc         = force_of(state);
    assign scl_force_o = frc.scl;
    assign sda_force_o = frc.sda;
    assign busy_o      = (state != ST_IDLE);

    a_r8_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !done_o && !ok_o && !scl_force_o && !sda_force_o));
    a_r1_high_skip: assert property (@(posedge clk) disable iff (rst)
        skip |=> (!busy_o && done_o && ok_o));
    a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_force_o && !sda_force_o));
    a_r3_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        pulses <= PC_W'(MAX_PULSES));
    a_r4_sda_with_scl: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_force_o) |-> scl_force_o);
    a_r4_sda_last: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_force_o) |-> (!scl_force_o && $past(!scl_force_o)));
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    a_r6_len_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(len_q));

endmodule

// File: rtl/busfree_seq.sv
module busfree_seq #(
    parameter int LEN_W      = 8,
    parameter int MAX_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             sda_i,
    input  logic [LEN_W-1:0] phase_len_i,
    output logic             scl_force_o,
    output logic             sda_force_o,
    output logic             done_o,
    output logic             ok_o,
    output logic             busy_o
);
    logic             load, expire;
    logic [LEN_W-1:0] load_val;

    busfree_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .len_i    (load_val),
        .expire_o (expire)
    );

    busfree_ctrl #(.LEN_W(LEN_W), .MAX_PULSES(MAX_PULSES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .sda_i       (sda_i),
        .phase_len_i (phase_len_i),
        .expire_i    (expire),
        .load_o      (load),
        .load_val_o  (load_val),
        .scl_force_o (scl_force_o),
        .sda_force_o (sda_force_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .busy_o      (busy_o)
    );

endmodule

// File: tb/test_busfree_seq.sv
module test_busfree_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;
    localparam int MAXP       = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] plen = '0;
    logic             scl_f, sda_f, done, ok, busy;
    int               hold_k = 0;
    int               rel_cnt = 0;
    logic             prev_scl = 1'b0;
    int               n_run = 0, n_fail = 0;
    logic             sda_line;

    assign sda_line = !sda_f && !(rel_cnt < hold_k);

    busfree_seq #(.LEN_W(LEN_W), .MAX_PULSES(MAXP)) i_busfree_seq (
        .clk(clk), .rst(rst), .start_i(start), .sda_i(sda_line),
        .phase_len_i(plen), .scl_force_o(scl_f), .sda_force_o(sda_f),
        .done_o(done), .ok_o(ok), .busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slave model: one clock release frees one held bit
    always @(negedge clk) begin
        if (prev_scl && !scl_f) rel_cnt = rel_cnt + 1;
        prev_scl = scl_f;
    end

    task automatic chk(input bit c, input string req, input int act, input int exp);
        n_run++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !scl_f && !sda_f && !done && !ok, "R8 reset state",
            {busy, scl_f, sda_f, done, ok}, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 12; k++) begin
                int ne, p, expbusy, bcnt, mism, i;
                bit expok;
                ne      = (n == 0) ? 1 : n;
                p       = (k == 0) ? 0 : ((k > MAXP) ? MAXP : k);
                expbusy = (k == 0) ? 0 : (2 * p + 3) * ne;
                expok   = (k <= MAXP + 1);
                hold_k  = k;
                rel_cnt = 0;
                plen    = LEN_W'(n);
                start   = 1'b1;
                @(negedge clk);
                start = 1'b0;
                bcnt = 0; mism = 0; i = 0;
                while (busy && i < 1000) begin
                    int ph;
                    bit es, ed;
                    ph = i / ne;
                    if (ph < 2 * p)          begin es = (ph % 2 == 0); ed = 1'b0; end
                    else if (ph == 2 * p)     begin es = 1'b1; ed = 1'b1; end
                    else if (ph == 2 * p + 1) begin es = 1'b0; ed = 1'b1; end
                    else                      begin es = 1'b0; ed = 1'b0; end
                    if (scl_f != es || sda_f != ed) mism++;
                    bcnt++;
                    // R6 / R7: new length and a trigger mid-run must not matter
                    if (i == 0) begin plen = 8'd7; start = 1'b1; end
                    else if (i == 1) start = 1'b0;
                    @(negedge clk);
                    i++;
                end
                start = 1'b0;
                chk(bcnt == expbusy, "R2 R3 R6 R7 busy length", bcnt, expbusy);
                chk(mism == 0, "R2 R4 override pattern mismatches", mism, 0);
                chk(done == 1'b1, "R5 R1 done at busy drop", done, 1);
                chk(ok == expok, "R5 R1 ok value", ok, expok);
                chk(!scl_f && !sda_f, "R2 overrides released", {scl_f, sda_f}, 0);
                @(negedge clk);
                chk(done == 1'b0, "R5 done single cycle", done, 0);
                chk(ok == expok && !busy, "R5 ok held", ok, expok);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule